// File: doc/BRIEF.md
# Link-Side Bus Control Handshake

This block sits at the link end of a two-wire control pair that is shared with a physical-layer device. While the physical layer drives the pair, the block turns the 2-bit code on `ctl_in` into separate indications for the upper logic:

- bus idle
- status being delivered
- incoming packet being delivered

When the physical layer presents the grant code, the block takes over the pair. From the next clock it drives its own codes: hold, transmit and release.

A transmit-side client steers the owned period with three signals:

- `tx_ready` means data is available.
- `tx_done` marks the last data cycle.
- `tx_req`, given together with `tx_done`, asks to chain another packet without new arbitration.

The block pulses `tx_take` on every cycle it drives the transmit code. After the client finishes, the block drives exactly one release cycle and then turns off its output enable. This hands the pair back to the physical layer.

Top module: `ctl_link_port`

## Requirements
- R1: While `rst_n` is low and on the first cycle after reset, `ctl_oe` is 0, `ctl_out` is 00 and `tx_take` is 0.
- R2: While `ctl_oe` is 0, exactly one of these indications is high for the sampled `ctl_in`: `phy_idle` for 00, `status_valid` for 01, `rx_active` for 10. All three are low when `ctl_in` is 11.
- R3: When `ctl_in` is 11 at a clock edge while `ctl_oe` is 0, `ctl_oe` is 1 from that edge on.
- R4: If `tx_ready` is 1 at the grant edge, the first owned cycle drives 10 (transmit). Otherwise it drives 01 (hold).
- R5: While the block drives hold, a clock edge with `tx_ready` at 1 switches `ctl_out` to 10. `tx_take` is 1 exactly in the cycles that drive 10.
- R6: While the block drives transmit, a clock edge with `tx_ready` at 0 and `tx_done` at 0 switches `ctl_out` back to 01.
- R7: While the block drives transmit, a clock edge with both `tx_done` and `tx_req` at 1 switches `ctl_out` to 01 and keeps ownership, chaining the next packet.
- R8: While the block drives transmit, a clock edge with `tx_done` at 1 and `tx_req` at 0 drives exactly one cycle of 00 with `ctl_oe` at 1. On the following cycle `ctl_oe` is 0.
- R9: While `ctl_oe` is 1, `ctl_in` has no effect: `phy_idle`, `status_valid` and `rx_active` stay 0, and the owned code sequence follows only the client inputs.
- R10: The block never drives the reserved code 11. `ctl_out` is 00 whenever `ctl_oe` is 0.
- R11: While the block drives hold, a clock edge with `tx_done` at 1 and `tx_ready` at 0 goes straight to the single release cycle of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_in | input | 2 | Control pair as sampled from the shared wires |
| ctl_out | output | 2 | Control code driven by the link |
| ctl_oe | output | 1 | Link drives the control pair when high |
| phy_idle | output | 1 | Physical layer reports idle bus |
| status_valid | output | 1 | Physical layer is delivering status |
| rx_active | output | 1 | Physical layer is delivering a received packet |
| tx_req | input | 1 | With `tx_done`, chain another packet |
| tx_ready | input | 1 | Client has transmit data available |
| tx_done | input | 1 | Client marks its last data cycle |
| tx_take | output | 1 | Transmit code driven; client data is consumed this cycle |

## Verification
The hardest situation to reach from the ports is a chained packet. It needs a grant, a transmit period, and a `tx_done` that coincides with `tx_req`. The hold code must then appear instead of release, and ownership must stay unbroken. The stimulus is a dedicated scenario:

1. It grants with data ready.
2. It finishes the first packet with `tx_req` high.
3. It stalls in hold.
4. It resumes transmit.
5. It ends with a plain release.

Garbage, including the grant code, is left on `ctl_in` throughout the owned period. This shows that the owned sequence ignores the physical-layer side.

// File: rtl/ctl_link_port.sv
module ctl_link_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ctl_in,
  output logic [1:0] ctl_out,
  output logic       ctl_oe,
  output logic       phy_idle,
  output logic       status_valid,
  output logic       rx_active,
  input  logic       tx_req,
  input  logic       tx_ready,
  input  logic       tx_done,
  output logic       tx_take
);
  localparam logic [1:0] C_IDLE  = 2'b00;
  localparam logic [1:0] C_STAT  = 2'b01;
  localparam logic [1:0] C_RECV  = 2'b10;
  localparam logic [1:0] C_GRANT = 2'b11;
  localparam logic [1:0] C_HOLD  = 2'b01;
  localparam logic [1:0] C_XMIT  = 2'b10;
  localparam logic [1:0] C_REL   = 2'b00;

  typedef enum logic [1:0] {S_PHY, S_HOLD, S_XMIT, S_REL} own_t;
  own_t st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      S_PHY:  if (ctl_in == C_GRANT) st_nx = tx_ready ? S_XMIT : S_HOLD;
      S_HOLD: if (tx_ready)          st_nx = S_XMIT;
              else if (tx_done)      st_nx = S_REL;
      S_XMIT: if (tx_done)           st_nx = tx_req ? S_HOLD : S_REL;
              else if (!tx_ready)    st_nx = S_HOLD;
      S_REL:                         st_nx = S_PHY;
      default:                       st_nx = S_PHY;
    endcase
  end

  always_ff @(posedge clk)
    if (!rst_n) st <= S_PHY;
    else        st <= st_nx;

  assign ctl_oe  = (st != S_PHY);
  assign tx_take = (st == S_XMIT);
  assign ctl_out = (st == S_HOLD) ? C_HOLD :
                   (st == S_XMIT) ? C_XMIT : C_REL;

  assign phy_idle     = !ctl_oe && (ctl_in == C_IDLE);
  assign status_valid = !ctl_oe && (ctl_in == C_STAT);
  assign rx_active    = !ctl_oe && (ctl_in == C_RECV);
endmodule

// File: rtl/ctl_link_port_chk.sv
module ctl_link_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ctl_in,
  input logic [1:0] ctl_out,
  input logic       ctl_oe,
  input logic       phy_idle,
  input logic       status_valid,
  input logic       rx_active,
  input logic       tx_req,
  input logic       tx_ready,
  input logic       tx_done,
  input logic       tx_take
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_oe |-> $countones({phy_idle, status_valid, rx_active}) == (ctl_in != 2'b11 ? 1 : 0));

  p_grant_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_oe && ctl_in == 2'b11) |=> ctl_oe);

  p_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && ctl_out == 2'b10 && tx_done && tx_req) |=> (ctl_oe && ctl_out == 2'b01));

  p_single_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && ctl_out == 2'b00) |=> !ctl_oe);

  p_owned_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_oe |-> !(phy_idle || status_valid || rx_active));

  p_no_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_out != 2'b11) && (ctl_oe || ctl_out == 2'b00));

  p_take_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take == (ctl_oe && ctl_out == 2'b10));
endmodule

bind ctl_link_port ctl_link_port_chk u_chk (.*);

// File: tb/ctl_link_port_test.sv
`timescale 1ns/1ps
module ctl_link_port_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] ctl_in = 0;
  logic       tx_req = 0, tx_ready = 0, tx_done = 0;
  logic [1:0] ctl_out;
  logic       ctl_oe, phy_idle, status_valid, rx_active, tx_take;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ctl_link_port uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic own(string req, logic oe, logic [1:0] code, logic take);
    check({req, " oe"}, ctl_oe, oe);
    check({req, " code"}, ctl_out, code);
    check({req, " take"}, tx_take, take);
  endtask

  task automatic t_reset();
    rst_n = 0; step(); own("R1 in reset", 0, 2'b00, 0);
    rst_n = 1; step(); own("R1 after reset", 0, 2'b00, 0);
  endtask

  task automatic t_decode();
    for (int c = 0; c < 4; c++) begin
      ctl_in = c[1:0]; #1;
      check("R2 idle",   phy_idle,     c == 0);
      check("R2 status", status_valid, c == 1);
      check("R2 recv",   rx_active,    c == 2);
      ctl_in = 0; step();
    end
  endtask

  task automatic t_grant_hold();
    tx_ready = 0; ctl_in = 2'b11; step();
    own("R3/R4 first owned hold", 1, 2'b01, 0);
    ctl_in = 2'b01; step();
    own("R5 waits in hold", 1, 2'b01, 0);
    check("R9 status masked", status_valid, 0);
    tx_ready = 1; ctl_in = 2'b00; step();
    own("R5 transmit after ready", 1, 2'b10, 1);
    check("R9 idle masked", phy_idle, 0);
    tx_done = 1; tx_req = 0; step();
    own("R8 release cycle", 1, 2'b00, 0);
    tx_done = 0; tx_ready = 0; step();
    own("R8 ownership returned", 0, 2'b00, 0);
    check("R2 idle after release", phy_idle, 1);
  endtask

  task automatic t_chain();
    tx_ready = 1; ctl_in = 2'b11; step();
    own("R4 first owned transmit", 1, 2'b10, 1);
    tx_done = 1; tx_req = 1; step();
    own("R7 chained hold", 1, 2'b01, 0);
    tx_done = 0; tx_req = 0; tx_ready = 0; step();
    own("R9 hold despite grant code", 1, 2'b01, 0);
    check("R9 recv masked", rx_active, 0);
    tx_ready = 1; ctl_in = 2'b10; step();
    own("R7 second packet", 1, 2'b10, 1);
    tx_done = 1; step();
    own("R8 release after chain", 1, 2'b00, 0);
    tx_done = 0; tx_ready = 0; ctl_in = 2'b00; step();
    own("R8 back to phy", 0, 2'b00, 0);
  endtask

  task automatic t_stall();
    tx_ready = 1; ctl_in = 2'b11; step();
    own("R4 transmit", 1, 2'b10, 1);
    ctl_in = 2'b00; tx_ready = 0; step();
    own("R6 stall to hold", 1, 2'b01, 0);
    tx_ready = 1; step();
    own("R6 resume", 1, 2'b10, 1);
    tx_ready = 0; tx_done = 1; step();
    own("R8 release", 1, 2'b00, 0);
    tx_done = 0; step();
    own("R8 released", 0, 2'b00, 0);
  endtask

  task automatic t_abandon();
    tx_ready = 0; ctl_in = 2'b11; step();
    own("R4 hold", 1, 2'b01, 0);
    ctl_in = 2'b00; tx_done = 1; step();
    own("R11 release from hold", 1, 2'b00, 0);
    tx_done = 0; step();
    own("R11 released", 0, 2'b00, 0);
    ctl_in = 2'b01; #1;
    check("R2 status after abandon", status_valid, 1);
    ctl_in = 2'b00; step();
  endtask

  initial begin
    t_reset();
    t_decode();
    t_grant_hold();
    t_chain();
    t_stall();
    t_abandon();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule